// File: doc/BRIEF.md
# Real-Time Counter with Alarm Compare

This block is a real-time clock peripheral meant to run from a slow crystal clock. A programmable prescaler divides the input clock by an even ratio and emits a one-cycle advance pulse. Each pulse moves a 32-bit free-running time counter forward by one. The default ratio gives sixteen counts per second from a 32768 Hz crystal, so the four low counter bits are sixteenths of a second and the upper bits are whole seconds.

Two alarm compare registers watch the counter. Each one sets its own flag when an advance brings the counter onto its value. A third flag marks every whole-second rollover of the sub-second field. Each flag has an enable bit in the same status word, and the single interrupt output is raised by any flag whose enable is set. Flags are cleared by writing one to them.

A clock-select register gates counting, and it only counts when it holds the run code. A 32-bit scratch register lets software keep an epoch count for counter wraps. The block does not change the scratch register. Software reaches everything through a simple single-cycle register bus: a write strobe with address and data, and combinational read data.

Top module: `rtca_top`

## Requirements
- R1: After reset the counter, both alarm compare registers, the scratch register and every status bit read 0. The divider reads 1023, the clock-select reads 0x3 and irq is 0.
- R2: While counting is enabled, the counter rises by exactly one every 2*(DIV+1) clock cycles. A write to the counter or to the divider restarts this interval, so the first increment lands 2*(DIV+1) cycles after the write.
- R3: A write to the counter (offset 0x00) loads the written value on that edge. Counting from 0xFFFFFFFF gives 0.
- R4: The tick flag (status bit 1) sets when an advance takes the low four counter bits from 0xF to 0x0. It stays clear on other advances.
- R5: Alarm flag 0 (status bit 0) sets on the advance that brings the counter equal to alarm register 0 (offset 0x04). Alarm flag 1 (status bit 4) does the same for alarm register 1 (offset 0x08).
- R6: A write to the status word (offset 0x0C) clears each flag (bits 0, 1, 4) whose written bit is 1 and leaves flags written with 0 unchanged. The enables (bit 2 alarm 0, bit 3 tick, bit 6 alarm 1) take the written bit values. A flag event in the same cycle as its clear wins.
- R7: irq is 1 exactly when some flag is 1 and its enable is 1.
- R8: Counting runs only while the clock-select register (offset 0x14, 8 bits) holds 0x03. Any other value freezes the counter.
- R9: The scratch register (offset 0x18) returns the last 32-bit value written to it. Nothing else changes it.
- R10: The divider (offset 0x10, 16 bits) and both alarm registers read back the values written. Status bits 5 and 7 to 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate counting and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The counter rate is checked cycle by cycle across several small divider values and the default one. This separates an off-by-one in the 2*(DIV+1) period from an error in restarting the prescaler phase. Counter loads just below an alarm value, a rollover point and the 32-bit wrap show whether a flag fires on the exact advance and not one count early or late. Status writes that mix ones and zeros over flags and enables show clear-on-one apart from plain overwrite. Clock-select values 0x2 and 0x7, and scratch reads taken while other registers change, show that gating and the scratch register are separate from the counting path.

// File: rtl/rtca_pkg.sv
package rtca_pkg;
  // register byte offsets
  localparam int OFF_COUNT = 'h00;
  localparam int OFF_ALM0  = 'h04;
  localparam int OFF_ALM1  = 'h08;
  localparam int OFF_STAT  = 'h0C;
  localparam int OFF_DIV   = 'h10;
  localparam int OFF_CSEL  = 'h14;
  localparam int OFF_SCR   = 'h18;

  // status word bit positions
  localparam int SB_TICK_F = 1;
  localparam int SB_TICK_E = 3;

  localparam int N_ALM     = 2;
  localparam logic [7:0] CSEL_RUN = 8'h03;

  function automatic int alarm_off(input int i);
    return (i == 0) ? OFF_ALM0 : OFF_ALM1;
  endfunction

  function automatic int alarm_flag_bit(input int i);
    return (i == 0) ? 0 : 4;
  endfunction

  function automatic int alarm_en_bit(input int i);
    return (i == 0) ? 2 : 6;
  endfunction
endpackage

// File: rtl/rtca_prescaler.sv
module rtca_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  output logic             adv
);
  localparam int PH_W = DIV_W + 1;

  // last phase of a 2*(div+1) cycle period
  function automatic logic [PH_W-1:0] phase_last(input logic [DIV_W-1:0] d);
    return {d, 1'b1};
  endfunction

  logic [PH_W-1:0] phase_q;
  logic            at_last;

  assign at_last = (phase_q == phase_last(div_val));
  assign adv     = run && !restart && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (run)     phase_q <= at_last ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/rtca_counter.sv
module rtca_counter #(
  parameter int CNT_W = 32,
  parameter int SUB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_next,
  output logic             step,
  output logic             rollover
);
  function automatic logic sub_full(input logic [CNT_W-1:0] c);
    return &c[SUB_W-1:0];
  endfunction

  assign step       = adv && !load;
  assign count_next = count + 1'b1;
  assign rollover   = step && sub_full(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count_next;
  end
endmodule

// File: rtl/rtca_alarm.sv
module rtca_alarm #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [CNT_W-1:0] count_next,
  output logic [CNT_W-1:0] cmp_q,
  output logic             hit
);
  assign hit = step && (count_next == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cmp_q <= '0;
    else if (load) cmp_q <= load_val;
  end
endmodule

// File: rtl/rtca_top.sv
module rtca_top
  import rtca_pkg::*;
#(
  parameter int DW      = 32,
  parameter int ADDR_W  = 8,
  parameter int DIV_W   = 16,
  parameter int SUB_W   = 4,
  parameter int RST_DIV = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  localparam int CNT_W  = DW;
  localparam int CSEL_W = 8;

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  logic             cnt_wr, div_wr, stat_wr, csel_wr, scr_wr;
  logic [DIV_W-1:0] div_q;
  logic [CSEL_W-1:0] csel_q;
  logic [DW-1:0]    scratch_q;
  logic             run;
  logic             adv_evt;
  logic [CNT_W-1:0] count, count_next;
  logic             step_evt, tick_evt;
  logic [N_ALM-1:0] al_hit, al_flag, al_en;
  logic [CNT_W-1:0] al_cmp [N_ALM];
  logic             tk_flag, tk_en;
  logic [DW-1:0]    stat_word;

  assign cnt_wr  = bus_wr && sel(bus_addr, OFF_COUNT);
  assign div_wr  = bus_wr && sel(bus_addr, OFF_DIV);
  assign stat_wr = bus_wr && sel(bus_addr, OFF_STAT);
  assign csel_wr = bus_wr && sel(bus_addr, OFF_CSEL);
  assign scr_wr  = bus_wr && sel(bus_addr, OFF_SCR);
  assign run     = (csel_q == CSEL_RUN);

  rtca_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(cnt_wr || div_wr),
    .div_val(div_q), .adv(adv_evt)
  );

  rtca_counter #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv_evt), .load(cnt_wr),
    .load_val(bus_wdata), .count(count), .count_next(count_next),
    .step(step_evt), .rollover(tick_evt)
  );

  for (genvar gi = 0; gi < N_ALM; gi++) begin : g_alm
    rtca_alarm #(.CNT_W(CNT_W)) u_alm (
      .clk(clk), .rst_n(rst_n),
      .load(bus_wr && sel(bus_addr, alarm_off(gi))),
      .load_val(bus_wdata), .step(step_evt), .count_next(count_next),
      .cmp_q(al_cmp[gi]), .hit(al_hit[gi])
    );
  end

  // config and scratch registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= DIV_W'(RST_DIV);
      csel_q    <= CSEL_RUN;
      scratch_q <= '0;
    end else begin
      if (div_wr)  div_q     <= bus_wdata[DIV_W-1:0];
      if (csel_wr) csel_q    <= bus_wdata[CSEL_W-1:0];
      if (scr_wr)  scratch_q <= bus_wdata;
    end
  end

  // status: flags set by events (priority), cleared by writing one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_flag <= '0;
      al_en   <= '0;
      tk_flag <= 1'b0;
      tk_en   <= 1'b0;
    end else begin
      for (int i = 0; i < N_ALM; i++) begin
        if (al_hit[i])
          al_flag[i] <= 1'b1;
        else if (stat_wr && bus_wdata[alarm_flag_bit(i)])
          al_flag[i] <= 1'b0;
        if (stat_wr) al_en[i] <= bus_wdata[alarm_en_bit(i)];
      end
      if (tick_evt)
        tk_flag <= 1'b1;
      else if (stat_wr && bus_wdata[SB_TICK_F])
        tk_flag <= 1'b0;
      if (stat_wr) tk_en <= bus_wdata[SB_TICK_E];
    end
  end

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < N_ALM; i++) begin
      stat_word[alarm_flag_bit(i)] = al_flag[i];
      stat_word[alarm_en_bit(i)]   = al_en[i];
    end
    stat_word[SB_TICK_F] = tk_flag;
    stat_word[SB_TICK_E] = tk_en;
  end

  assign irq = (|(al_flag & al_en)) || (tk_flag && tk_en);

  always_comb begin
    bus_rdata = '0;
    if (sel(bus_addr, OFF_COUNT)) bus_rdata = count;
    if (sel(bus_addr, OFF_ALM0))  bus_rdata = al_cmp[0];
    if (sel(bus_addr, OFF_ALM1))  bus_rdata = al_cmp[1];
    if (sel(bus_addr, OFF_STAT))  bus_rdata = stat_word;
    if (sel(bus_addr, OFF_DIV))   bus_rdata = DW'(div_q);
    if (sel(bus_addr, OFF_CSEL))  bus_rdata = DW'(csel_q);
    if (sel(bus_addr, OFF_SCR))   bus_rdata = scratch_q;
  end
endmodule

// File: rtl/rtca_chk.sv
module rtca_chk
  import rtca_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              irq,
  input logic              adv_evt,
  input logic              cnt_wr,
  input logic              run,
  input logic [DW-1:0]     count,
  input logic [DW-1:0]     scratch_q,
  input logic [DW-1:0]     stat_word,
  input logic [N_ALM-1:0]  al_hit,
  input logic              tick_evt
);
  logic stat_sel, scr_sel;
  assign stat_sel = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
  assign scr_sel  = bus_wr && (bus_addr == ADDR_W'(OFF_SCR));

  // R2
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt && !cnt_wr |=> count == $past(count) + 1'b1);

  // R2
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_evt && !cnt_wr |=> $stable(count));

  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(bus_wdata));

  // R8
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |-> run);

  // R4
  tick_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> stat_word[SB_TICK_F]);

  // R5
  alarm0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    al_hit[0] |=> stat_word[alarm_flag_bit(0)]);

  // R5
  alarm1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    al_hit[1] |=> stat_word[alarm_flag_bit(1)]);

  // R6
  w1c_alarm0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel && bus_wdata[alarm_flag_bit(0)] && !al_hit[0]
      |=> !stat_word[alarm_flag_bit(0)]);

  // R6
  w0_keep_alarm0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel && !bus_wdata[alarm_flag_bit(0)] && stat_word[alarm_flag_bit(0)]
      |=> stat_word[alarm_flag_bit(0)]);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_word[0] && !stat_word[1] && !stat_word[4] |-> !irq);

  // R9
  scratch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_sel |=> $stable(scratch_q));
endmodule

bind rtca_top rtca_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .adv_evt(adv_evt), .cnt_wr(cnt_wr),
  .run(run), .count(count), .scratch_q(scratch_q), .stat_word(stat_word),
  .al_hit(al_hit), .tick_evt(tick_evt)
);

// File: tb/rtca_top_bench.sv
`timescale 1ns/1ps
module rtca_top_bench;
  localparam logic [7:0] A_CNT = 8'h00, A_AL0 = 8'h04, A_AL1 = 8'h08,
                         A_ST = 8'h0C, A_DIV = 8'h10, A_CS = 8'h14,
                         A_SCR = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rtca_top u_rtca_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    int divs [5] = '{0, 1, 2, 3, 7};
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CNT, v); chk("R1 counter", v, 32'h0);
    rd(A_AL0, v); chk("R1 alarm0", v, 32'h0);
    rd(A_AL1, v); chk("R1 alarm1", v, 32'h0);
    rd(A_ST, v);  chk("R1 status", v, 32'h0);
    rd(A_DIV, v); chk("R1 divider", v, 32'd1023);
    rd(A_CS, v);  chk("R1 clock-select", v, 32'h3);
    rd(A_SCR, v); chk("R1 scratch", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 default divider: 2048 cycles per count
    wr(A_CNT, 32'd100);
    step(2047); rd(A_CNT, v); chk("R2 default before edge", v, 32'd100);
    step(1);    rd(A_CNT, v); chk("R2 default at edge", v, 32'd101);

    // R2 sweep small dividers, every cycle over three periods
    foreach (divs[j]) begin
      int per;
      per = 2 * (divs[j] + 1);
      wr(A_DIV, divs[j]);
      rd(A_DIV, v); chk("R10 divider readback", v, divs[j]);
      wr(A_CNT, 32'h1000);
      for (int k = 0; k <= 3 * per; k++) begin
        rd(A_CNT, v);
        chk("R2 rate sweep", v, 32'h1000 + k / per);
        step(1);
      end
    end

    // R3 wrap with tick at 0xF -> 0x0
    wr(A_DIV, 0);
    wr(A_ST, 32'h13);
    wr(A_CNT, 32'hFFFF_FFFE);
    step(2); rd(A_CNT, v); chk("R3 before wrap", v, 32'hFFFF_FFFF);
    step(2); rd(A_CNT, v); chk("R3 wrap to zero", v, 32'h0);
    rd(A_ST, v); chk("R4 tick on wrap", v & 32'h2, 32'h2);

    // R4 tick flag, R7 tick interrupt
    wr(A_ST, 32'h13);
    wr(A_CNT, 32'h2E);
    step(2); rd(A_ST, v); chk("R4 no tick at 0x2F", v & 32'h2, 32'h0);
    step(2); rd(A_CNT, v); chk("R4 count 0x30", v, 32'h30);
    rd(A_ST, v); chk("R4 tick at 0x30", v & 32'h2, 32'h2);
    chk("R7 tick flag without enable", {31'b0, irq}, 32'h0);
    wr(A_ST, 32'h08);
    chk("R7 tick flag with enable", {31'b0, irq}, 32'h1);
    wr(A_ST, 32'h0A);
    rd(A_ST, v); chk("R6 tick cleared enable kept", v & 32'h0A, 32'h08);
    chk("R7 irq after tick clear", {31'b0, irq}, 32'h0);
    wr(A_ST, 32'h00);

    // R5 alarm 0
    wr(A_ST, 32'h13);
    wr(A_AL0, 32'h105);
    rd(A_AL0, v); chk("R10 alarm0 readback", v, 32'h105);
    wr(A_ST, 32'h04);
    wr(A_CNT, 32'h100);
    step(9); rd(A_CNT, v); chk("R5 count 0x104", v, 32'h104);
    rd(A_ST, v); chk("R5 alarm0 not early", v & 32'h1, 32'h0);
    chk("R7 no irq before alarm0", {31'b0, irq}, 32'h0);
    step(1); rd(A_CNT, v); chk("R5 count 0x105", v, 32'h105);
    rd(A_ST, v); chk("R5 alarm0 flag", v & 32'h1, 32'h1);
    chk("R7 alarm0 irq", {31'b0, irq}, 32'h1);
    wr(A_ST, 32'h04);
    rd(A_ST, v); chk("R6 write zero keeps alarm0", v & 32'h5, 32'h5);
    wr(A_ST, 32'h05);
    rd(A_ST, v); chk("R6 write one clears alarm0", v & 32'h5, 32'h4);
    chk("R7 irq after alarm0 clear", {31'b0, irq}, 32'h0);

    // R5 alarm 1
    wr(A_ST, 32'h00);
    wr(A_AL1, 32'h20F);
    rd(A_AL1, v); chk("R10 alarm1 readback", v, 32'h20F);
    wr(A_CNT, 32'h20C);
    step(5); rd(A_ST, v); chk("R5 alarm1 not early", v & 32'h10, 32'h0);
    step(1); rd(A_CNT, v); chk("R5 count 0x20F", v, 32'h20F);
    rd(A_ST, v); chk("R5 alarm1 flag", v & 32'h10, 32'h10);
    chk("R7 alarm1 flag without enable", {31'b0, irq}, 32'h0);
    wr(A_ST, 32'h40);
    chk("R7 alarm1 with enable", {31'b0, irq}, 32'h1);
    wr(A_ST, 32'h50);
    rd(A_ST, v); chk("R6 alarm1 cleared", v & 32'h50, 32'h40);
    chk("R7 irq after alarm1 clear", {31'b0, irq}, 32'h0);

    // R10 unused status bits
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, v); chk("R10 unused status bits", v & ~32'h5F, 32'h0);
    wr(A_ST, 32'h13);

    // R8 clock-select gating
    wr(A_CNT, 32'h500);
    wr(A_CS, 32'h2);
    rd(A_CS, v); chk("R8 clock-select readback", v, 32'h2);
    rd(A_CNT, c0);
    step(40); rd(A_CNT, v); chk("R8 frozen at 0x2", v, c0);
    wr(A_CS, 32'h7);
    step(40); rd(A_CNT, v); chk("R8 frozen at 0x7", v, c0);
    wr(A_CS, 32'h3);
    step(20); rd(A_CNT, v); chk("R8 resumes at 0x3", {31'b0, v != c0}, 32'h1);
    wr(A_CNT, 32'h600);
    step(6); rd(A_CNT, v); chk("R2 after resume", v, 32'h603);

    // R9 scratch
    wr(A_SCR, 32'hDEAD_BEEF);
    step(50);
    wr(A_CNT, 32'h5);
    wr(A_ST, 32'h13);
    wr(A_DIV, 32'h3);
    rd(A_SCR, v); chk("R9 scratch held", v, 32'hDEAD_BEEF);
    wr(A_SCR, 32'h1234_5678);
    rd(A_SCR, v); chk("R9 scratch rewritten", v, 32'h1234_5678);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule